// File: doc/BRIEF.md
# Reference-Compare Interval Timer

This block is a free-standing up-counter behind a small byte-addressed register bus. A programmable prescaler divides the system clock into count ticks. The divisor is the 8-bit prescale field plus one. A clock-select setting can multiply that divisor by a fixed 16. The counter climbs toward a software-loaded reference value. When it gets there, a sticky reference event flag is raised. That flag can drive a registered interrupt line when the interrupt enable in the mode word is set.

Software programs the block through single-cycle register writes and combinational reads. There is no back-pressure: every write presented with `bus_we` high is taken on that rising clock edge, and `bus_rdata` always reflects the register selected by `bus_addr`. The count can be reloaded at any time. After a match the counter either returns to zero or keeps running and wraps. Clearing the run bit turns the timer off and clears its setup. The capture register is plain storage with no capture logic behind it.

Top module: `tmr_ref_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: The register map is mode at byte offset 0x00, reference at 0x04, capture at 0x08, count at 0x0C and event at 0x11 (event bit 1 = reference, bit 0 = capture; no capture source exists). Capture stores and returns what is written. Any other offset reads 0, and writes to it change no register.
- R3: The count advances only while mode bit 0 is 1 and the clock-select field (mode bits 2:1) is 1 or 2. Select values 0 and 3, or bit 0 = 0, hold the count.
- R4: The count advances once every (P+1) clocks, where P = mode bits 15:8, or every 16*(P+1) clocks when select is 2. A write to the mode or reference register restarts this division: the first increment lands on the edge that comes (divisor) clocks after the write edge.
- R5: A write to the count register loads the written value on that edge, even while running. The load takes priority over any increment or restart.
- R6: On the clock edge after the one where counting (not a load) makes the count equal to the reference, event bit 1 becomes 1.
- R7: With mode bit 3 (restart) set, the count is 0 on that same following edge, and a concurrent increment is discarded. With bit 3 clear, counting continues and 0xFFFF steps to 0x0000.
- R8: A write to the event register clears each event bit written as 1 and keeps each bit written as 0. A new reference event on the same edge wins over the clear.
- R9: A mode write that takes bit 0 from 1 to 0 leaves both the mode and reference registers at 0, whatever other data was written.
- R10: `irq` equals, one clock later, mode bit 4 AND event bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, taken on the rising edge |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Registered reference-event interrupt |

## Verification
The hardest case to reach is a software clear of the event register that lands on the same edge as a new reference event. The two must collide with no slack. The stimulus runs the prescaler at divide-by-one with restart on, so the match period is exactly reference+1 clocks. It then issues the write-one-to-clear on the edge it has computed, so that edge is the one carrying the delayed match. The prescaler restart is exposed by rewriting the reference partway through a 32-clock division and timing the next increment from that write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Register byte offsets on the bus
  localparam int unsigned OFF_MODE = 'h00;
  localparam int unsigned OFF_REF  = 'h04;
  localparam int unsigned OFF_CAP  = 'h08;
  localparam int unsigned OFF_CNT  = 'h0C;
  localparam int unsigned OFF_EV   = 'h11;

  // Mode word bit positions
  localparam int unsigned B_RUN     = 0;
  localparam int unsigned B_SEL_LO  = 1;
  localparam int unsigned B_SEL_HI  = 2;
  localparam int unsigned B_RESTART = 3;
  localparam int unsigned B_IRQ_EN  = 4;
  localparam int unsigned PSC_LSB   = 8;
  localparam int unsigned MODE_LOW_W = 8;

  // Event bit positions
  localparam int unsigned EV_CAP = 0;
  localparam int unsigned EV_REF = 1;

  // Clock-select codes
  typedef enum logic [1:0] {
    SEL_STOP0 = 2'd0,
    SEL_DIV   = 2'd1,
    SEL_DIV16 = 2'd2,
    SEL_STOP3 = 2'd3
  } clk_sel_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PSC_W   = 8,
  parameter int DIV_FIX = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PSC_W-1:0] psc,
  input  logic             fix_div,
  output logic             tick
);
  localparam int FIX_SH = $clog2(DIV_FIX);
  localparam int PRE_W  = PSC_W + FIX_SH;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] div_m1;

  generate
    if (FIX_SH == 0) begin : g_nofix
      logic unused_fix;
      assign unused_fix = fix_div;
      assign div_m1 = psc;
    end else begin : g_fix
      // (P+1)*2^k - 1 equals P shifted left k with ones filled in
      assign div_m1 = fix_div ? {psc, {FIX_SH{1'b1}}} : PRE_W'(psc);
    end
  endgenerate

  assign tick = run && (pre_q == div_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (restart || !run || tick) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart_en,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] ref_val,
  output logic [CNT_W-1:0] count_q,
  output logic             hit_q
);
  logic [CNT_W-1:0] count_inc;
  logic             hit;

  assign count_inc = count_q + 1'b1;
  // A match is only reached by counting, never by a load
  assign hit = tick && !load && (count_inc == ref_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      hit_q   <= 1'b0;
    end else begin
      hit_q <= hit;
      if (load) begin
        count_q <= load_val;
      end else if (hit_q && restart_en) begin
        count_q <= '0;
      end else if (tick) begin
        count_q <= count_inc;
      end
    end
  end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int MODE_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic [CNT_W-1:0]  count_q,
  input  logic              ref_event,
  output logic [MODE_W-1:0] mode_q,
  output logic [CNT_W-1:0]  ref_q,
  output logic [1:0]        ev_q,
  output logic              div_restart,
  output logic              cnt_load,
  output logic              irq
);
  logic [CNT_W-1:0] cap_q;
  logic             sel_mode, sel_ref, sel_cap, sel_cnt, sel_ev;
  logic             wr_mode, wr_ref, wr_cap, wr_ev;
  logic             shut_off;
  logic [1:0]       ev_clr;
  logic [1:0]       ev_set;

  assign sel_mode = (bus_addr == ADDR_W'(OFF_MODE));
  assign sel_ref  = (bus_addr == ADDR_W'(OFF_REF));
  assign sel_cap  = (bus_addr == ADDR_W'(OFF_CAP));
  assign sel_cnt  = (bus_addr == ADDR_W'(OFF_CNT));
  assign sel_ev   = (bus_addr == ADDR_W'(OFF_EV));

  assign wr_mode  = bus_we && sel_mode;
  assign wr_ref   = bus_we && sel_ref;
  assign wr_cap   = bus_we && sel_cap;
  assign wr_ev    = bus_we && sel_ev;
  assign cnt_load = bus_we && sel_cnt;

  assign div_restart = wr_mode || wr_ref;
  assign shut_off    = wr_mode && mode_q[B_RUN] && !bus_wdata[B_RUN];

  assign ev_clr = wr_ev ? bus_wdata[1:0] : 2'b00;
  always_comb begin
    ev_set = 2'b00;
    ev_set[EV_REF] = ref_event;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ref_q  <= '0;
      cap_q  <= '0;
      ev_q   <= '0;
      irq    <= 1'b0;
    end else begin
      if (shut_off) begin
        mode_q <= '0;
        ref_q  <= '0;
      end else begin
        if (wr_mode) mode_q <= bus_wdata[MODE_W-1:0];
        if (wr_ref)  ref_q  <= bus_wdata;
      end
      if (wr_cap) cap_q <= bus_wdata;
      // a fresh event outranks a simultaneous clear
      ev_q <= (ev_q & ~ev_clr) | ev_set;
      irq  <= mode_q[B_IRQ_EN] && ev_q[EV_REF];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_mode)     bus_rdata = CNT_W'(mode_q);
    else if (sel_ref) bus_rdata = ref_q;
    else if (sel_cap) bus_rdata = cap_q;
    else if (sel_cnt) bus_rdata = count_q;
    else if (sel_ev)  bus_rdata = CNT_W'(ev_q);
  end
endmodule

// File: rtl/tmr_ref_timer.sv
module tmr_ref_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PSC_W   = 8,
  parameter int DIV_FIX = 16,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);
  localparam int MODE_W = MODE_LOW_W + PSC_W;

  logic [MODE_W-1:0] mode_q;
  logic [CNT_W-1:0]  ref_q;
  logic [CNT_W-1:0]  count_q;
  logic [1:0]        ev_q;
  logic              hit_q;
  logic              div_restart;
  logic              cnt_load;
  logic              tick;
  logic              running;
  clk_sel_e          sel;
  logic              unused_mode_bits;

  assign sel     = clk_sel_e'(mode_q[B_SEL_HI:B_SEL_LO]);
  assign running = mode_q[B_RUN] && ((sel == SEL_DIV) || (sel == SEL_DIV16));
  assign unused_mode_bits = ^mode_q[MODE_LOW_W-1:B_IRQ_EN+1];

  tmr_regs #(
    .CNT_W  (CNT_W),
    .MODE_W (MODE_W),
    .ADDR_W (ADDR_W)
  ) i_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .count_q     (count_q),
    .ref_event   (hit_q),
    .mode_q      (mode_q),
    .ref_q       (ref_q),
    .ev_q        (ev_q),
    .div_restart (div_restart),
    .cnt_load    (cnt_load),
    .irq         (irq)
  );

  tmr_prescaler #(
    .PSC_W   (PSC_W),
    .DIV_FIX (DIV_FIX)
  ) i_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (running),
    .restart (div_restart),
    .psc     (mode_q[MODE_W-1:PSC_LSB]),
    .fix_div (sel == SEL_DIV16),
    .tick    (tick)
  );

  tmr_counter #(
    .CNT_W (CNT_W)
  ) i_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .restart_en (mode_q[B_RESTART]),
    .load       (cnt_load),
    .load_val   (bus_wdata),
    .ref_val    (ref_q),
    .count_q    (count_q),
    .hit_q      (hit_q)
  );
endmodule

// File: rtl/tmr_ref_timer_chk.sv
module tmr_ref_timer_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int MODE_W = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [CNT_W-1:0]  bus_wdata,
  input logic [MODE_W-1:0] mode_q,
  input logic [CNT_W-1:0]  ref_q,
  input logic [CNT_W-1:0]  count_q,
  input logic [1:0]        ev_q,
  input logic              hit_q,
  input logic              irq
);
  logic cnt_wr, ev_ref_wr, mode_wr, run_now;
  assign cnt_wr    = bus_we && (bus_addr == ADDR_W'(OFF_CNT));
  assign ev_ref_wr = bus_we && (bus_addr == ADDR_W'(OFF_EV)) && bus_wdata[EV_REF];
  assign mode_wr   = bus_we && (bus_addr == ADDR_W'(OFF_MODE));
  assign run_now   = mode_q[B_RUN] && (mode_q[B_SEL_HI:B_SEL_LO] == 2'd1 || mode_q[B_SEL_HI:B_SEL_LO] == 2'd2);

  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!run_now && !cnt_wr && !hit_q) |-> count_q == $past(count_q)); // R3

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cnt_wr) |-> count_q == $past(bus_wdata)); // R5

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hit_q && mode_q[B_RESTART] && !cnt_wr) |-> count_q == '0); // R7

  AST_EV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ev_q[EV_REF] && !ev_ref_wr) |-> ev_q[EV_REF]); // R8

  AST_SHUTOFF_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_wr && mode_q[B_RUN] && !bus_wdata[B_RUN]) |-> (mode_q == '0 && ref_q == '0)); // R9

  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(mode_q[B_IRQ_EN] && ev_q[EV_REF])); // R10
endmodule

bind tmr_ref_timer tmr_ref_timer_chk #(
  .CNT_W  (CNT_W),
  .MODE_W (MODE_W),
  .ADDR_W (ADDR_W)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .mode_q    (mode_q),
  .ref_q     (ref_q),
  .count_q   (count_q),
  .ev_q      (ev_q),
  .hit_q     (hit_q),
  .irq       (irq)
);

// File: tb/test_tmr_ref_timer.sv
`timescale 1ns/1ps
module test_tmr_ref_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [7:0] A_MODE = 8'h00, A_REF = 8'h04, A_CAP = 8'h08,
                         A_CNT = 8'h0C, A_EV = 8'h11;

  typedef struct packed {
    logic        we;
    logic [7:0]  addr;
    logic [15:0] data;
    logic [15:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'h08, 16'hA5C3, 16'hA5C3, 8'd2},  // R2 capture storage
    '{1'b1, 8'h04, 16'h0100, 16'h0100, 8'd2},  // R2 reference
    '{1'b0, 8'h20, 16'h0000, 16'h0000, 8'd2},  // R2 unmapped read
    '{1'b1, 8'h10, 16'hFFFF, 16'h0000, 8'd2},  // R2 unmapped write
    '{1'b0, 8'h08, 16'h0000, 16'hA5C3, 8'd2},  // R2 capture untouched
    '{1'b1, 8'h00, 16'hAB00, 16'hAB00, 8'd2},  // R2 mode, stopped
    '{1'b1, 8'h0C, 16'h0042, 16'h0042, 8'd5},  // R5 load
    '{1'b0, 8'h0C, 16'h0000, 16'h0042, 8'd3}   // R3 held while stopped
  };

  tmr_ref_timer i_tmr_ref_timer (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // called at a negedge; write lands on the next rising edge
  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [15:0] exp, input string tag);
    bus_addr = a;
    #1;
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s addr=%02h actual=%04h expected=%04h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_MODE, 16'h0, "R1 mode");
    rd(A_REF,  16'h0, "R1 ref");
    rd(A_CAP,  16'h0, "R1 cap");
    rd(A_CNT,  16'h0, "R1 count");
    rd(A_EV,   16'h0, "R1 event");
    chk_irq(1'b0, "R1");

    // vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].we) wr(VEC[i].addr, VEC[i].data);
      rd(VEC[i].addr, VEC[i].exp, $sformatf("R%0d vector %0d", VEC[i].req, i));
    end

    // restart on reference, divide by 1, irq enabled
    wr(A_REF, 16'd3);
    wr(A_CNT, 16'd0);
    wr(A_MODE, 16'h001B);            // edge E0
    step(3);                         // after E3
    rd(A_CNT, 16'd3, "R6 count reaches ref");
    rd(A_EV, 16'd0, "R6 event not yet");
    step(1);                         // after E4
    rd(A_CNT, 16'd0, "R7 restart to zero");
    rd(A_EV, 16'd2, "R6 event set");
    chk_irq(1'b0, "R10 irq lags event");
    step(1);                         // after E5
    chk_irq(1'b1, "R10 irq asserted");
    step(2);                         // after E7
    wr(A_EV, 16'h0002);              // lands on E8, the next event edge
    rd(A_EV, 16'd2, "R8 event wins over clear");
    wr(A_EV, 16'h0002);              // E9
    rd(A_EV, 16'd0, "R8 write-one clears");
    wr(A_MODE, 16'hFFFE);            // E10, run bit falls
    rd(A_MODE, 16'd0, "R9 mode cleared");
    rd(A_REF, 16'd0, "R9 ref cleared");
    step(5);
    rd(A_CNT, 16'd2, "R3 stopped after shut-off");

    // divide by 16*(1+1) = 32, prescaler restart by ref write
    wr(A_CNT, 16'd0);
    wr(A_MODE, 16'h0105);            // E0
    step(20);
    wr(A_REF, 16'd0);                // E21 restarts division
    step(31);                        // after E52
    rd(A_CNT, 16'd0, "R4 no tick before divisor");
    step(1);                         // after E53
    rd(A_CNT, 16'd1, "R4 tick after divisor");
    wr(A_MODE, 16'h0000);

    // no restart, wrap through 0xFFFF
    wr(A_REF, 16'd5);
    wr(A_CNT, 16'hFFFE);
    wr(A_MODE, 16'h0013);            // E0
    step(2);
    rd(A_CNT, 16'h0000, "R7 wrap to zero");
    step(6);                         // after E8
    rd(A_CNT, 16'd6, "R7 keeps counting past ref");
    rd(A_EV, 16'd2, "R6 event without restart");
    chk_irq(1'b0, "R10 irq one clock late");
    step(1);
    chk_irq(1'b1, "R10 irq follows event");
    wr(A_EV, 16'h0001);
    rd(A_EV, 16'd2, "R8 zero bit keeps event");
    wr(A_EV, 16'h0002);
    rd(A_EV, 16'd0, "R8 event cleared");
    step(1);
    chk_irq(1'b0, "R10 irq drops");
    wr(A_MODE, 16'h0000);

    // select 0 and 3 hold, load while running
    wr(A_CNT, 16'd7);
    wr(A_MODE, 16'h0001);
    step(10);
    rd(A_CNT, 16'd7, "R3 select 0 holds");
    wr(A_MODE, 16'h0007);
    step(10);
    rd(A_CNT, 16'd7, "R3 select 3 holds");
    wr(A_MODE, 16'h0003);
    step(3);
    wr(A_CNT, 16'h1000);
    rd(A_CNT, 16'h1000, "R5 load while running");
    step(1);
    rd(A_CNT, 16'h1001, "R5 counting resumes from load");

    finish_run();
  end
endmodule